// File: doc/BRIEF.md
# Serial Flash Command Engine

This block runs one short command against a serial flash device over a single data lane. Typical uses are reading an identification or status value, setting the write latch, or erasing a sector at a given address. Software supplies one packed control word. It also supplies an address value and up to eight bytes of outgoing data, split across a lower and an upper 32-bit word. Writing the control word with the execute bit set starts the command. The engine then sends the opcode, an optional address, an optional run of idle clocks, optional write bytes, and collects optional read bytes.

While the command runs, the in-progress flag stays high. The flag drops when chip select has been released, and at that moment the received bytes are already in the two result words. Software writes the control word once with execute clear to set it up, writes it again with execute set, and then polls until in-progress reads 0. Every serial bit takes two system clocks: the serial clock is low in the first and high in the second.

Top module: `flash_cmd_engine`

## Requirements
- R1: After reset, busy is 0, spi_cs_n is 1, spi_sclk is 0 and both result words are zero.
- R2: A control word written with bit 0 (execute) clear starts nothing. A control word written with bit 0 set while idle raises busy and lowers spi_cs_n in the next cycle.
- R3: The opcode in bits 31:24 is sent first, most significant bit first.
- R4: When bit 19 is set, the address follows the opcode. The byte count is bits 17:16 plus one. The low bytes of the address input are sent most significant byte first, and each byte is sent MSB first.
- R5: Bits 11:7 give a number of idle serial clocks, from 0 to 31, that follow the address. spi_mosi is 0 during these clocks and during the read phase.
- R6: When bit 15 is set, write bytes follow the idle clocks. The byte count is bits 14:12 plus one. Byte k comes from bits 8k+7:8k of {wr_hi, wr_lo}, so bytes 0 to 3 come from the lower word and bytes 4 to 7 from the upper word. Each byte is sent MSB first.
- R7: When bit 23 is set, read bytes come last. The byte count is bits 22:20 plus one. Received byte k is placed in bits 8k+7:8k of {rd_hi, rd_lo}, with its first serial bit as the MSB. Byte positions that were not received read as zero.
- R8: Each serial bit lasts two clocks: spi_sclk is low in the first and high in the second. spi_mosi changes only when spi_sclk falls. For a command of N serial clocks, busy falls and spi_cs_n rises 2N+1 cycles after the launching edge.
- R9: Setting execute while busy has no effect on the running command, and no second command follows it.
- R10: rd_lo and rd_hi hold their values while busy is high and change only at completion.
- R11: Phases whose enable bit is clear, or whose idle count is zero, are skipped. An opcode-only command uses 8 serial clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Control word write strobe |
| cmd_word | input | 32 | Packed control word |
| cmd_addr | input | 32 | Address value for the address phase |
| wr_lo | input | 32 | Write bytes 0 to 3 |
| wr_hi | input | 32 | Write bytes 4 to 7 |
| busy | output | 1 | In-progress flag |
| rd_lo | output | 32 | Received bytes 0 to 3 |
| rd_hi | output | 32 | Received bytes 4 to 7 |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
Busy and chip select change one cycle after the strobe edge. Each serial bit then takes exactly two cycles, and completion comes 2N+1 cycles after launch. The bench counts the falling clock edges during which busy is high and compares that count to 2N+1, where N is worked out from the control word fields. Outgoing bits are recorded at the falling system clock that follows each rise of spi_sclk. The slave model changes spi_miso only after spi_sclk falls, so each read bit is steady through the whole high cycle in which it is sampled. Result words are read only after busy has dropped, and are also compared midway through the command to confirm they have not moved.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  parameter int WORD_W  = 32;
  parameter int BUF_W   = 2 * WORD_W;
  parameter int POS_W   = $clog2(BUF_W);
  parameter int IDX_W   = POS_W + 1;
  parameter int CNT_W   = 3;
  parameter int ACNT_W  = 2;
  parameter int IDLE_W  = 5;

  typedef enum logic [2:0] {
    PH_IDLE, PH_OP, PH_ADDR, PH_DUMMY, PH_WR, PH_RD, PH_END
  } phase_e;

  typedef struct packed {
    logic [7:0]        opcode;
    logic              rd_en;
    logic [CNT_W-1:0]  rd_cnt;
    logic              addr_en;
    logic [ACNT_W-1:0] addr_cnt;
    logic              wr_en;
    logic [CNT_W-1:0]  wr_cnt;
    logic [IDLE_W-1:0] idle_clks;
    logic              exec;
  } cmd_t;
endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output cmd_t              cmd
);
  always_comb begin
    cmd.exec      = word[0];
    cmd.idle_clks = word[11:7];
    cmd.wr_cnt    = word[14:12];
    cmd.wr_en     = word[15];
    cmd.addr_cnt  = word[17:16];
    cmd.addr_en   = word[19];
    cmd.rd_cnt    = word[22:20];
    cmd.rd_en     = word[23];
    cmd.opcode    = word[31:24];
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  cmd_t              cmd_in,
  input  logic [WORD_W-1:0] addr_in,
  input  logic [BUF_W-1:0]  wdata_in,
  output logic              busy,
  output logic              cs_n,
  output logic              sclk,
  output logic              mosi,
  output logic              clr,
  output logic              cap_en,
  output logic [POS_W-1:0]  cap_pos,
  output logic              commit
);
  phase_e             phase;
  logic               half;
  logic [IDX_W-1:0]   idx;
  cmd_t               cmd_q;
  logic [WORD_W-1:0]  addr_q;
  logic [BUF_W-1:0]   wdat_q;
  logic               launch;
  logic               last_bit;
  phase_e             nxt_phase;
  logic [IDX_W-1:0]   idx_inc;

  function automatic logic [IDX_W-1:0] bytes_to_bits(input logic [CNT_W-1:0] cnt);
    logic [IDX_W-1:0] b;
    b = IDX_W'(cnt) + IDX_W'(1);
    return b << 3;
  endfunction

  function automatic logic [IDX_W-1:0] phase_len(input phase_e p, input cmd_t c);
    logic [IDX_W-1:0] n;
    case (p)
      PH_OP:    n = IDX_W'(8);
      PH_ADDR:  n = bytes_to_bits(CNT_W'(c.addr_cnt));
      PH_DUMMY: n = IDX_W'(c.idle_clks);
      PH_WR:    n = bytes_to_bits(c.wr_cnt);
      PH_RD:    n = bytes_to_bits(c.rd_cnt);
      default:  n = IDX_W'(1);
    endcase
    return n;
  endfunction

  function automatic phase_e phase_after(input phase_e p, input cmd_t c);
    phase_e r;
    r = PH_END;
    if (p == PH_OP && c.addr_en)
      r = PH_ADDR;
    else if ((p == PH_OP || p == PH_ADDR) && c.idle_clks != '0)
      r = PH_DUMMY;
    else if ((p == PH_OP || p == PH_ADDR || p == PH_DUMMY) && c.wr_en)
      r = PH_WR;
    else if (p != PH_RD && p != PH_END && p != PH_IDLE && c.rd_en)
      r = PH_RD;
    return r;
  endfunction

  function automatic logic tx_bit(input phase_e p, input logic [IDX_W-1:0] i,
                                  input cmd_t c, input logic [WORD_W-1:0] a,
                                  input logic [BUF_W-1:0] w);
    logic [IDX_W-1:0] pos;
    logic             b;
    b = 1'b0;
    case (p)
      PH_OP:   b = c.opcode[3'd7 - i[2:0]];
      PH_ADDR: begin
        pos = phase_len(PH_ADDR, c) - IDX_W'(1) - i;
        b   = a[pos[4:0]];
      end
      PH_WR:   b = w[{i[POS_W-1:3], 3'd7 - i[2:0]}];
      default: b = 1'b0;
    endcase
    return b;
  endfunction

  assign launch    = strobe && cmd_in.exec && (phase == PH_IDLE);
  assign idx_inc   = idx + IDX_W'(1);
  assign last_bit  = (idx_inc == phase_len(phase, cmd_q));
  assign nxt_phase = phase_after(phase, cmd_q);

  assign clr     = launch;
  assign cap_en  = (phase == PH_RD) && half;
  assign cap_pos = {idx[POS_W-1:3], 3'd7 - idx[2:0]};
  assign commit  = (phase == PH_END);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_IDLE;
      half   <= 1'b0;
      idx    <= '0;
      busy   <= 1'b0;
      cs_n   <= 1'b1;
      sclk   <= 1'b0;
      mosi   <= 1'b0;
      cmd_q  <= '0;
      addr_q <= '0;
      wdat_q <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (launch) begin
            cmd_q  <= cmd_in;
            addr_q <= addr_in;
            wdat_q <= wdata_in;
            phase  <= PH_OP;
            idx    <= '0;
            half   <= 1'b0;
            busy   <= 1'b1;
            cs_n   <= 1'b0;
            sclk   <= 1'b0;
            mosi   <= cmd_in.opcode[7];
          end
        end
        PH_END: begin
          phase <= PH_IDLE;
          busy  <= 1'b0;
          cs_n  <= 1'b1;
          mosi  <= 1'b0;
        end
        default: begin
          if (!half) begin
            sclk <= 1'b1;
            half <= 1'b1;
          end else begin
            sclk <= 1'b0;
            half <= 1'b0;
            if (last_bit) begin
              phase <= nxt_phase;
              idx   <= '0;
              mosi  <= tx_bit(nxt_phase, '0, cmd_q, addr_q, wdat_q);
            end else begin
              idx  <= idx_inc;
              mosi <= tx_bit(phase, idx_inc, cmd_q, addr_q, wdat_q);
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/flash_cmd_rxpack.sv
module flash_cmd_rxpack
  import flash_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             cap_en,
  input  logic [POS_W-1:0] cap_pos,
  input  logic             din,
  input  logic             commit,
  output logic [BUF_W-1:0] result
);
  logic [BUF_W-1:0] acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      result <= '0;
    end else begin
      if (clr)
        acc <= '0;
      else if (cap_en)
        acc[cap_pos] <= din;
      if (commit)
        result <= acc;
    end
  end
endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
  import flash_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic [WORD_W-1:0] cmd_word,
  input  logic [WORD_W-1:0] cmd_addr,
  input  logic [WORD_W-1:0] wr_lo,
  input  logic [WORD_W-1:0] wr_hi,
  output logic              busy,
  output logic [WORD_W-1:0] rd_lo,
  output logic [WORD_W-1:0] rd_hi,
  output logic              spi_cs_n,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  cmd_t             cmd;
  logic             clr;
  logic             cap_en;
  logic [POS_W-1:0] cap_pos;
  logic             commit;
  logic [BUF_W-1:0] result;

  flash_cmd_decode u_dec (
    .word (cmd_word),
    .cmd  (cmd)
  );

  flash_cmd_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .strobe   (cmd_wr),
    .cmd_in   (cmd),
    .addr_in  (cmd_addr),
    .wdata_in ({wr_hi, wr_lo}),
    .busy     (busy),
    .cs_n     (spi_cs_n),
    .sclk     (spi_sclk),
    .mosi     (spi_mosi),
    .clr      (clr),
    .cap_en   (cap_en),
    .cap_pos  (cap_pos),
    .commit   (commit)
  );

  flash_cmd_rxpack u_rx (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .cap_en  (cap_en),
    .cap_pos (cap_pos),
    .din     (spi_miso),
    .commit  (commit),
    .result  (result)
  );

  assign rd_lo = result[WORD_W-1:0];
  assign rd_hi = result[BUF_W-1:WORD_W];
endmodule

// File: rtl/flash_cmd_engine_chk.sv
module flash_cmd_engine_chk
  import flash_cmd_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              cmd_wr,
  input logic [WORD_W-1:0] cmd_word,
  input logic              busy,
  input logic [WORD_W-1:0] rd_lo,
  input logic [WORD_W-1:0] rd_hi,
  input logic              spi_cs_n,
  input logic              spi_sclk,
  input logic              spi_mosi
);
  p_launch_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && cmd_wr && cmd_word[0]) |=> (busy && !spi_cs_n));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && !(cmd_wr && cmd_word[0])) |=> !busy);

  p_sclk_parked_r8: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sclk);

  p_cs_with_busy_r8: assert property (@(posedge clk) disable iff (rst)
    busy |-> !spi_cs_n);

  p_mosi_steady_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_sclk) |-> $stable(spi_mosi));

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!busy || ($stable(rd_lo) && $stable(rd_hi))));
endmodule

bind flash_cmd_engine flash_cmd_engine_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .cmd_wr   (cmd_wr),
  .cmd_word (cmd_word),
  .busy     (busy),
  .rd_lo    (rd_lo),
  .rd_hi    (rd_hi),
  .spi_cs_n (spi_cs_n),
  .spi_sclk (spi_sclk),
  .spi_mosi (spi_mosi)
);

// File: tb/flash_cmd_engine_tb.sv
module flash_cmd_engine_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_wr = 1'b0;
  logic [31:0] cmd_word = '0;
  logic [31:0] cmd_addr = '0;
  logic [31:0] wr_lo = '0;
  logic [31:0] wr_hi = '0;
  logic        busy;
  logic [31:0] rd_lo;
  logic [31:0] rd_hi;
  logic        spi_cs_n;
  logic        spi_sclk;
  logic        spi_mosi;
  logic        spi_miso = 1'b0;

  int total = 0;
  int bad = 0;

  logic       cap [0:255];
  logic       exp_s [0:255];
  int         exp_n;
  int         rise_n = 0;
  int         fall_n = 0;
  logic       sclk_prev = 1'b0;
  logic       cs_prev = 1'b1;
  int         pre_bits = 0;
  logic [7:0] rbytes [0:7];

  always #10 clk = ~clk;

  flash_cmd_engine u_dut (
    .clk (clk), .rst (rst), .cmd_wr (cmd_wr), .cmd_word (cmd_word),
    .cmd_addr (cmd_addr), .wr_lo (wr_lo), .wr_hi (wr_hi), .busy (busy),
    .rd_lo (rd_lo), .rd_hi (rd_hi), .spi_cs_n (spi_cs_n),
    .spi_sclk (spi_sclk), .spi_mosi (spi_mosi), .spi_miso (spi_miso)
  );

  // flash model: records mosi after each sclk rise, shifts miso after each fall
  always @(negedge clk) begin
    int j;
    if (!spi_cs_n && cs_prev) begin
      rise_n = 0;
      fall_n = 0;
    end
    if (!spi_cs_n && spi_sclk && !sclk_prev) begin
      if (rise_n < 256) cap[rise_n] = spi_mosi;
      rise_n++;
    end
    if (!spi_cs_n && !spi_sclk && sclk_prev) fall_n++;
    sclk_prev = spi_sclk;
    cs_prev   = spi_cs_n;
    j = fall_n - pre_bits;
    if (!spi_cs_n && j >= 0 && j < 64) spi_miso = rbytes[j/8][7 - (j%8)];
    else spi_miso = 1'b0;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic push_byte(input logic [7:0] b);
    for (int k = 7; k >= 0; k--) begin
      exp_s[exp_n] = b[k];
      exp_n++;
    end
  endtask

  task automatic push_zeros(input int n);
    for (int k = 0; k < n; k++) begin
      exp_s[exp_n] = 1'b0;
      exp_n++;
    end
  endtask

  // launches a command, optionally strobes a second execute word mid-flight
  task automatic run_cmd(input logic [31:0] w, input logic [31:0] a,
                         input logic [31:0] dl, input logic [31:0] dh,
                         input bit inject, input logic [31:0] w2,
                         input string req);
    int cyc;
    int mism;
    logic [31:0] lo_before;
    lo_before = rd_lo;
    @(negedge clk);
    cmd_word = w; cmd_addr = a; wr_lo = dl; wr_hi = dh; cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
    check(busy === 1'b1 && spi_cs_n === 1'b0, "R2", "launch", {busy, spi_cs_n}, 2'b10);
    cyc = 0;
    while (busy === 1'b1 && cyc < 2000) begin
      cyc++;
      if (cyc == exp_n) check(rd_lo === lo_before, "R10", "rd_lo mid-command", rd_lo, lo_before);
      if (inject && cyc == 6) begin
        cmd_word = w2; cmd_addr = ~a; wr_lo = ~dl; cmd_wr = 1'b1;
      end
      if (inject && cyc == 7) cmd_wr = 1'b0;
      @(negedge clk);
    end
    check(cyc == 2 * exp_n + 1, "R8", {req, " busy cycles"}, cyc, 2 * exp_n + 1);
    check(spi_cs_n === 1'b1, "R8", "cs released", spi_cs_n, 1);
    check(rise_n == exp_n, req, "serial clock count", rise_n, exp_n);
    mism = -1;
    for (int k = exp_n - 1; k >= 0; k--) if (cap[k] !== exp_s[k]) mism = k;
    check(mism < 0, req, "serial stream first mismatch bit", mism, exp_s[(mism < 0) ? 0 : mism]);
  endtask

  task automatic t_reset;
    check(busy === 1'b0 && spi_cs_n === 1'b1 && spi_sclk === 1'b0, "R1",
          "idle pins", {busy, spi_cs_n, spi_sclk}, 3'b010);
    check({rd_hi, rd_lo} === 64'd0, "R1", "result words", {rd_hi, rd_lo}, 0);
  endtask

  task automatic t_no_exec;
    @(negedge clk);
    cmd_word = 32'h9FA0_0000; cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
    repeat (10) @(negedge clk);
    check(busy === 1'b0 && spi_cs_n === 1'b1, "R2", "no execute", {busy, spi_cs_n}, 2'b01);
  endtask

  task automatic t_opcode_only;
    exp_n = 0; push_byte(8'h06); pre_bits = 1000;
    run_cmd(32'h0600_0001, 32'h0, 32'h0, 32'h0, 1'b0, 32'h0, "R11");
    check(exp_n == 8, "R3", "opcode length", exp_n, 8);
  endtask

  task automatic t_erase_addr;
    exp_n = 0; push_byte(8'hD8); push_byte(8'h12); push_byte(8'h34); push_byte(8'h56);
    pre_bits = 1000;
    run_cmd(32'hD80A_0001, 32'hAB12_3456, 32'h0, 32'h0, 1'b0, 32'h0, "R4");
  endtask

  task automatic t_full;
    logic [7:0] rb [0:7];
    rb = '{8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'hE5, 8'hF6, 8'h07, 8'h18};
    for (int k = 0; k < 8; k++) rbytes[k] = rb[k];
    exp_n = 0;
    push_byte(8'h5A);
    push_byte(8'h89); push_byte(8'hAB); push_byte(8'hCD); push_byte(8'hEF);
    push_zeros(5);
    push_byte(8'h11); push_byte(8'h22); push_byte(8'h33); push_byte(8'h44); push_byte(8'h55);
    pre_bits = exp_n;
    push_zeros(64);
    run_cmd(32'h5AFB_C281, 32'h89AB_CDEF, 32'h4433_2211, 32'h9988_7755, 1'b0, 32'h0, "R6");
    check(pre_bits == 85, "R5", "idle clocks placed before write data", pre_bits, 85);
    check(rd_lo === 32'hD4C3_B2A1, "R7", "rd_lo eight bytes", rd_lo, 32'hD4C3_B2A1);
    check(rd_hi === 32'h1807_F6E5, "R7", "rd_hi eight bytes", rd_hi, 32'h1807_F6E5);
  endtask

  task automatic t_read_id;
    rbytes[0] = 8'h9C; rbytes[1] = 8'h41; rbytes[2] = 8'h27;
    for (int k = 3; k < 8; k++) rbytes[k] = 8'hFF;
    exp_n = 0; push_byte(8'h9F); pre_bits = 8; push_zeros(24);
    run_cmd(32'h9FA0_0001, 32'h0, 32'h0, 32'h0, 1'b0, 32'h0, "R7");
    check(rd_lo === 32'h0027_419C, "R7", "rd_lo three bytes", rd_lo, 32'h0027_419C);
    check(rd_hi === 32'h0, "R7", "rd_hi unreceived zero", rd_hi, 0);
  endtask

  task automatic t_exec_while_busy;
    rbytes[0] = 8'h5B;
    exp_n = 0; push_byte(8'h05); pre_bits = 8; push_zeros(8);
    run_cmd(32'h0580_0001, 32'h0, 32'h0, 32'h0, 1'b1, 32'h9FF0_0001, "R9");
    check(rd_lo === 32'h0000_005B && rd_hi === 32'h0, "R9", "result of first command",
          {rd_hi, rd_lo}, 64'h5B);
    repeat (6) @(negedge clk);
    check(busy === 1'b0 && spi_cs_n === 1'b1, "R9", "no follow-on command", {busy, spi_cs_n}, 2'b01);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 8; k++) rbytes[k] = 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_no_exec();
    t_opcode_only();
    t_erase_addr();
    t_full();
    t_read_id();
    t_exec_while_busy();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule